// File: doc/BRIEF.md
# Power-On Reset and Watchdog Supervisor

This block produces the reset line for a host processor. After power is applied, it keeps the host in reset for a fixed delay so that the supply and the clock can settle. It also pulls reset whenever an external comparator reports that the supply has dropped below its trip level. After the supply recovers, it keeps reset asserted for the same settle delay before it lets go. A watchdog with a selectable timeout watches for host activity. If the host fails to show any activity within the chosen window, the watchdog pulses reset.

Time is measured in ticks of a slow reference strobe that arrives as an input, nominally 4096 per second. With the default parameters, the settle delay is 1024 ticks. The watchdog windows are 1024, 3072 or 7168 ticks, and a fourth setting switches the watchdog off. The reset pin is open drain, so the block does not output a logic level. It outputs a pull-down enable instead, and a pad turns that enable into the open-drain pin.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_good` is low, `rst_pull` is 1. After `pwr_good` goes high, `rst_pull` stays 1 until HOLD_TICKS tick strobes have been sampled. It returns to 0 in the cycle after the HOLD_TICKS-th tick.
- R2: When `low_vdd` is sampled high, `rst_pull` is 1 from the next cycle and stays 1 for as long as `low_vdd` stays high.
- R3: After `low_vdd` falls, `rst_pull` stays 1 for HOLD_TICKS more ticks. If `low_vdd` rises during any hold interval, including a watchdog pulse, the hold count restarts from zero.
- R4: `wdt_sel` sets the watchdog window in units of WDT_QUARTER ticks: 2'b00 gives 1 unit, 2'b01 gives 3 units and 2'b10 gives 7 units. With 2'b11 the watchdog never causes a reset.
- R5: With reset released and no host activity, `rst_pull` rises in the cycle after the tick that completes the window. That pulse lasts HOLD_TICKS ticks, and the window then starts again from zero.
- R6: A `kick` strobe sampled high restarts the window from zero. A kick in the same cycle as the tick that would have ended the window prevents the expiry.
- R7: Any change of `wdt_sel` while reset is released restarts the window from zero.
- R8: Neither the hold count nor the watchdog window advances in a cycle where `tick` is low.
- R9: `rst_pull` = 1 means the open-drain reset line is driven low (reset active). `rst_pull` = 0 means the line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | High once power is applied; low acts as synchronous reset |
| low_vdd | input | 1 | Supply-below-trip flag from the analog comparator |
| tick | input | 1 | One-cycle strobe at the timebase rate |
| kick | input | 1 | Host activity strobe, services the watchdog |
| wdt_sel | input | 2 | Watchdog window select (R4 encoding) |
| rst_pull | output | 1 | Pull-down enable for the open-drain active-low reset pin |

## Verification
The hardest case to reach from the ports is a kick that lands exactly on the tick that would otherwise end the watchdog window. The bench gets there by counting ticks from the release edge and raising `kick` on the last tick of the window. It does this repeatedly, so an off-by-one in either direction shows up as a spurious pulse. Two other cases are tested with the same approach: a select change made partway through a window, and a supply-low event during a watchdog-initiated pulse. In each case the bench picks the point of the event so that a restart and a plain continuation of the count give different pulse times.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        WDT_ONE   = 2'b00,
        WDT_THREE = 2'b01,
        WDT_SEVEN = 2'b10,
        WDT_OFF   = 2'b11
    } wdt_sel_e;

    typedef enum logic {
        SUP_HOLD = 1'b0,
        SUP_RUN  = 1'b1
    } sup_state_e;

    // events seen by the supervisor in one cycle
    typedef struct packed {
        logic tick;
        logic low_vdd;
        logic restart;
        logic expire;
        logic hold_done;
    } sup_evt_t;

    // window length in units of the quarter period
    function automatic int unsigned wdt_units(wdt_sel_e s);
        case (s)
            WDT_ONE:   return 1;
            WDT_THREE: return 3;
            WDT_SEVEN: return 7;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/rsv_hold_timer.sv
module rsv_hold_timer #(
    parameter int unsigned HOLD_TICKS = 1024,
    localparam int unsigned CW = $clog2(HOLD_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt;

    assign done = active && !clear && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || !active || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rsv_sel_track.sv
module rsv_sel_track (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    output logic       changed
);
    logic [1:0] sel_q;

    assign changed = (sel != sel_q);

    always_ff @(posedge clk) begin
        sel_q <= sel;
        if (rst) begin
            sel_q <= sel;
        end
    end
endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog
    import rsv_pkg::*;
#(
    parameter int unsigned WDT_QUARTER = 1024,
    localparam int unsigned MAXW = 7 * WDT_QUARTER,
    localparam int unsigned CW = $clog2(MAXW + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       expire
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic          enabled;

    always_comb begin
        enabled = (wdt_sel_e'(sel) != WDT_OFF);
        last    = CW'(wdt_units(wdt_sel_e'(sel)) * WDT_QUARTER - 1);
    end

    assign expire = run && enabled && !restart && tick && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run || restart || expire) begin
            cnt <= '0;
        end else if (tick && enabled) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsv_pkg::*;
#(
    parameter int unsigned HOLD_TICKS  = 1024,
    parameter int unsigned WDT_QUARTER = 1024
) (
    input  logic       clk,
    input  logic       pwr_good,
    input  logic       low_vdd,
    input  logic       tick,
    input  logic       kick,
    input  logic [1:0] wdt_sel,
    output logic       rst_pull
);
    sup_state_e state;
    sup_evt_t   ev;
    logic       rst;
    logic       sel_changed;
    logic       in_run;

    assign rst    = !pwr_good;
    assign in_run = (state == SUP_RUN);

    rsv_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .active (!in_run),
        .clear  (low_vdd),
        .tick   (tick),
        .done   (ev.hold_done)
    );

    rsv_sel_track u_sel (
        .clk     (clk),
        .rst     (rst),
        .sel     (wdt_sel),
        .changed (sel_changed)
    );

    always_comb begin
        ev.tick    = tick;
        ev.low_vdd = low_vdd;
        ev.restart = kick || sel_changed;
    end

    rsv_watchdog #(.WDT_QUARTER(WDT_QUARTER)) u_wdt (
        .clk     (clk),
        .rst     (rst),
        .run     (in_run && !low_vdd),
        .restart (ev.restart),
        .tick    (tick),
        .sel     (wdt_sel),
        .expire  (ev.expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SUP_HOLD;
        end else begin
            case (state)
                SUP_HOLD: if (ev.hold_done) state <= SUP_RUN;
                SUP_RUN:  if (ev.low_vdd || ev.expire) state <= SUP_HOLD;
                default:  state <= SUP_HOLD;
            endcase
        end
    end

    // open-drain model: enable pulls the active-low line down
    assign rst_pull = !in_run;
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
    parameter int unsigned HOLD_TICKS = 1024
) (
    input logic       clk,
    input logic       pwr_good,
    input logic       low_vdd,
    input logic       tick,
    input logic       kick,
    input logic [1:0] wdt_sel,
    input logic       rst_pull
);
    int unsigned held;

    always_ff @(posedge clk) begin
        if (!pwr_good || !rst_pull || low_vdd) held <= 0;
        else if (tick) held <= held + 1;
    end

    p_low_asserts_r2: assert property (@(posedge clk) disable iff (!pwr_good)
        low_vdd |=> rst_pull);

    p_release_clean_r3: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(rst_pull) |-> !$past(low_vdd));

    p_release_on_tick_r8: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(rst_pull) |-> $past(tick));

    p_hold_length_r1: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(rst_pull) |-> (held == HOLD_TICKS));

    p_kick_wins_r6: assert property (@(posedge clk) disable iff (!pwr_good)
        (!rst_pull && kick && !low_vdd) |=> !rst_pull);

    p_off_no_expiry_r4: assert property (@(posedge clk) disable iff (!pwr_good)
        (!rst_pull && wdt_sel == 2'b11 && !low_vdd) |=> !rst_pull);
endmodule

bind rst_supervisor rsv_checker #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
    .clk      (clk),
    .pwr_good (pwr_good),
    .low_vdd  (low_vdd),
    .tick     (tick),
    .kick     (kick),
    .wdt_sel  (wdt_sel),
    .rst_pull (rst_pull)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
    localparam int HOLD = 5;
    localparam int Q    = 3;

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic       low_vdd = 1'b0;
    logic       tick = 1'b1;
    logic       kick = 1'b0;
    logic [1:0] wdt_sel = 2'b00;
    logic       rst_pull;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rst_supervisor #(.HOLD_TICKS(HOLD), .WDT_QUARTER(Q)) i_rst_supervisor (
        .clk(clk), .pwr_good(pwr_good), .low_vdd(low_vdd), .tick(tick),
        .kick(kick), .wdt_sel(wdt_sel), .rst_pull(rst_pull)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // count edges until rst_pull drops
    task automatic meas_high(output int n);
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); @(negedge clk); n++;
            if (!rst_pull) break;
        end
    endtask

    // count edges until rst_pull rises
    task automatic meas_low(output int n);
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); @(negedge clk); n++;
            if (rst_pull) break;
        end
    endtask

    task automatic power_up(input logic [1:0] s);
        int n;
        @(negedge clk); pwr_good = 1'b0; wdt_sel = s;
        repeat (2) @(negedge clk);
        check("R1 off", int'(rst_pull), 1);
        pwr_good = 1'b1;
        meas_high(n);
        check("R1 hold", n, HOLD);
    endtask

    function automatic int window(input int s);
        return (s == 0) ? Q : (s == 1) ? 3 * Q : 7 * Q;
    endfunction

    initial begin
        int n;
        int bad;
        repeat (3) @(negedge clk);
        check("R9 reset polarity", int'(rst_pull), 1);

        // R8: no ticks, no release
        tick = 1'b0; pwr_good = 1'b1;
        bad = 0;
        repeat (20) begin @(negedge clk); if (!rst_pull) bad++; end
        check("R8 hold frozen", bad, 0);
        tick = 1'b1;
        meas_high(n);
        check("R1 hold after ticks resume", n, HOLD);

        // R4/R5: windows per select
        for (int s = 0; s < 3; s++) begin
            power_up(2'(s));
            meas_low(n);
            check("R4 window", n, window(s));
            meas_high(n);
            check("R5 pulse length", n, HOLD);
            meas_low(n);
            check("R5 window restarts", n, window(s));
        end

        // R4: disabled
        power_up(2'b11);
        bad = 0;
        repeat (80) begin @(negedge clk); if (rst_pull) bad++; end
        check("R4 disabled", bad, 0);

        // R6: kick on the final tick, repeatedly
        power_up(2'b00);
        bad = 0;
        for (int k = 0; k < 15; k++) begin
            repeat (Q - 1) begin @(negedge clk); if (rst_pull) bad++; end
            kick = 1'b1;
            @(negedge clk); kick = 1'b0;
            if (rst_pull) bad++;
        end
        check("R6 kick on last tick", bad, 0);
        meas_low(n);
        check("R6 window after kick", n, Q);

        // R8: watchdog frozen without ticks
        meas_high(n);
        tick = 1'b0;
        bad = 0;
        repeat (30) begin @(negedge clk); if (rst_pull) bad++; end
        check("R8 window frozen", bad, 0);
        tick = 1'b1;
        meas_low(n);
        check("R8 window resumes", n, Q);

        // R7: select change mid window
        power_up(2'b00);
        repeat (2) @(negedge clk);
        wdt_sel = 2'b01;
        meas_low(n);
        check("R7 select restart", n, 1 + 3 * Q);

        // R2/R3: supply low in run
        power_up(2'b11);
        low_vdd = 1'b1;
        @(negedge clk);
        check("R2 low asserts", int'(rst_pull), 1);
        bad = 0;
        repeat (12) begin @(negedge clk); if (!rst_pull) bad++; end
        check("R2 held while low", bad, 0);
        low_vdd = 1'b0;
        meas_high(n);
        check("R3 recovery hold", n, HOLD);

        // R3: supply low during watchdog pulse restarts hold
        power_up(2'b00);
        meas_low(n);
        repeat (2) @(negedge clk);
        low_vdd = 1'b1;
        @(negedge clk); low_vdd = 1'b0;
        meas_high(n);
        check("R3 restart in wdt pulse", n, HOLD);

        // R1: power loss in run
        power_up(2'b11);
        pwr_good = 1'b0;
        @(negedge clk);
        check("R1 power loss", int'(rst_pull), 1);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule